// File: doc/BRIEF.md
# Interrupt Entry Bus Sequencer

This block walks an 8-bit processor with a 16-bit address bus through the bus cycles of an exception entry: power-up reset, non-maskable interrupt, maskable interrupt and the software break. The block owns the address bus, the write-data bus and the read/write strobe for the whole entry. It saves the return address and the status byte on a stack that always lives in page one. It then reads a two-byte vector from the top of memory and hands the resulting program counter back to the core.

An arbiter raises `start_i` for one cycle together with a cause code while the sequencer is idle. The core keeps `pc_i`, `sp_i` and `p_i` stable through the first sequence cycle, and the block samples them there. After reset is released, the sequencer runs the reset entry without any request. Every entry uses the same eight-cycle frame. Two lead-in reads come first, then three stack cycles, two vector reads and the opcode fetch from the new address. On the fetch cycle `done_o` pulses, and `pc_o`, `sp_o` and `p_o` carry the values the core should adopt.

Top module: `irq_entry_seq`

## Requirements
- R1: Cycle 1 is the cycle in which reset is released or the first cycle after a request is accepted. With this numbering, the reset entry drives read (`rw_o`=1) on every cycle, reads the vector from 0xFFFC (low) and 0xFFFD (high) on cycles 6 and 7, and performs the opcode fetch on cycle 8.
- R2: Cycles 3, 4 and 5 address 0x0100+SP, 0x0100+SP-1 and 0x0100+SP-2, where the 8-bit stack pointer wraps modulo 256 and the high byte stays 0x01.
- R3: For the causes other than reset, cycles 3, 4 and 5 are writes (`rw_o`=0) of PC high, PC low and the status byte, in that order. No write ever leaves page one.
- R4: The cause codes are 0 for reset, 1 for NMI, 2 for IRQ and 3 for BRK. The vector pair read on cycles 6 and 7 is 0xFFFA/0xFFFB for NMI, 0xFFFC/0xFFFD for reset, and 0xFFFE/0xFFFF for IRQ and BRK.
- R5: On cycle 8 the address bus and `pc_o` equal the high byte read on cycle 7 joined with the low byte read on cycle 6.
- R6: On cycle 8, `p_o` equals the sampled status with bit 2 (interrupt disable) set.
- R7: BRK pushes the sampled PC plus 2, with a 16-bit wrap, and a status byte whose bit 4 is set. IRQ and NMI push the sampled PC and a status byte whose bit 4 is cleared. All other status bits are pushed unchanged.
- R8: On cycle 8, `sp_o` equals the sampled SP minus 3, modulo 256. This holds for reset as well.
- R9: `done_o` is high on cycle 8 only, and `busy_o` is low on the cycle after. A `start_i` pulse or a change of cause while busy has no effect on the running entry.
- R10: Cycles 1 and 2 are reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset; the reset entry runs on release |
| start_i | input | 1 | Entry request, taken only while idle |
| cause_i | input | 2 | Entry cause: 0 reset, 1 NMI, 2 IRQ, 3 BRK |
| pc_i | input | 16 | Current program counter (address of BRK for a break) |
| sp_i | input | 8 | Current stack pointer |
| p_i | input | 8 | Current status byte |
| rdata_i | input | 8 | Read data bus |
| addr_o | output | 16 | Address bus |
| wdata_o | output | 8 | Write data bus |
| rw_o | output | 1 | 1 = read, 0 = write |
| busy_o | output | 1 | Entry in progress |
| done_o | output | 1 | One-cycle pulse on the opcode fetch cycle |
| pc_o | output | 16 | New program counter (the vector) |
| sp_o | output | 8 | Updated stack pointer |
| p_o | output | 8 | Updated status with interrupt disable set |

## Verification
A wrong step state shows on the address bus in the very cycle it occurs. The result is a vector address off by two, a stack address that breaks the descending run, or a write strobe during reset. A stale or mis-decremented stack pointer shows up on cycles 3 to 5 and again in `sp_o` on cycle 8. A vector byte captured in the wrong cycle becomes visible only on cycle 8, at the fetch address and in `pc_o`.

// File: rtl/entry_pkg.sv
package entry_pkg;

    typedef enum logic [1:0] {
        CAUSE_RESET = 2'd0,
        CAUSE_NMI   = 2'd1,
        CAUSE_IRQ   = 2'd2,
        CAUSE_BRK   = 2'd3
    } cause_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LEAD0,
        ST_LEAD1,
        ST_PUSH0,
        ST_PUSH1,
        ST_PUSH2,
        ST_VLO,
        ST_VHI,
        ST_FETCH
    } step_e;

endpackage

// File: rtl/entry_vec_map.sv
module entry_vec_map
    import entry_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  cause_e              cause_i,
    output logic [ADDR_W-1:0]   vec_lo_addr_o
);
    localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

    // Vector low byte sits at an even address below the top of memory.
    always_comb begin
        unique case (cause_i)
            CAUSE_NMI:   vec_lo_addr_o = TOP_ADDR - ADDR_W'(5);
            CAUSE_RESET: vec_lo_addr_o = TOP_ADDR - ADDR_W'(3);
            default:     vec_lo_addr_o = TOP_ADDR - ADDR_W'(1);
        endcase
    end
endmodule

// File: rtl/entry_push_mux.sv
module entry_push_mux #(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int BRK_BIT = 4
) (
    input  logic [1:0]          idx_i,
    input  logic                brk_i,
    input  logic [ADDR_W-1:0]   pc_i,
    input  logic [DATA_W-1:0]   st_i,
    output logic [DATA_W-1:0]   byte_o
);
    logic [ADDR_W-1:0] ret_pc;
    logic [DATA_W-1:0] st_push;

    always_comb begin
        ret_pc           = brk_i ? pc_i + ADDR_W'(2) : pc_i;
        st_push          = st_i;
        st_push[BRK_BIT] = brk_i;
        unique case (idx_i)
            2'd0:    byte_o = ret_pc[ADDR_W-1 -: DATA_W];
            2'd1:    byte_o = ret_pc[DATA_W-1:0];
            default: byte_o = st_push;
        endcase
    end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import entry_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter logic [ADDR_W-DATA_W-1:0] STACK_PAGE = 1,
    parameter int IDIS_BIT = 2,
    parameter int BRK_BIT  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [1:0]          cause_i,
    input  logic [ADDR_W-1:0]   pc_i,
    input  logic [DATA_W-1:0]   sp_i,
    input  logic [DATA_W-1:0]   p_i,
    input  logic [DATA_W-1:0]   rdata_i,
    output logic [ADDR_W-1:0]   addr_o,
    output logic [DATA_W-1:0]   wdata_o,
    output logic                rw_o,
    output logic                busy_o,
    output logic                done_o,
    output logic [ADDR_W-1:0]   pc_o,
    output logic [DATA_W-1:0]   sp_o,
    output logic [DATA_W-1:0]   p_o
);
    localparam logic [DATA_W-1:0] IDIS_MASK = DATA_W'(1) << IDIS_BIT;

    typedef struct packed {
        step_e              step;
        cause_e             cause;
        logic [ADDR_W-1:0]  pc;
        logic [DATA_W-1:0]  sp;
        logic [DATA_W-1:0]  st;
        logic [DATA_W-1:0]  vlo;
        logic [DATA_W-1:0]  vhi;
    } seq_t;

    seq_t seq_q, seq_d;

    logic [ADDR_W-1:0] vec_lo_addr;
    logic [DATA_W-1:0] push_byte;
    logic [1:0]        push_idx;
    logic              is_reset;
    logic [ADDR_W-1:0] new_pc;

    entry_vec_map #(.ADDR_W(ADDR_W)) u_vec (
        .cause_i       (seq_q.cause),
        .vec_lo_addr_o (vec_lo_addr)
    );

    entry_push_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BRK_BIT(BRK_BIT)) u_push (
        .idx_i  (push_idx),
        .brk_i  (seq_q.cause == CAUSE_BRK),
        .pc_i   (seq_q.pc),
        .st_i   (seq_q.st),
        .byte_o (push_byte)
    );

    assign is_reset = (seq_q.cause == CAUSE_RESET);
    assign new_pc   = ADDR_W'({seq_q.vhi, seq_q.vlo});

    always_comb begin
        seq_d    = seq_q;
        addr_o   = pc_i;
        rw_o     = 1'b1;
        done_o   = 1'b0;
        push_idx = 2'd0;
        unique case (seq_q.step)
            ST_IDLE: begin
                if (start_i) begin
                    seq_d.step  = ST_LEAD0;
                    seq_d.cause = cause_e'(cause_i);
                end
            end
            ST_LEAD0: begin
                addr_o     = pc_i;
                seq_d.pc   = pc_i;
                seq_d.sp   = sp_i;
                seq_d.st   = p_i;
                seq_d.step = ST_LEAD1;
            end
            ST_LEAD1: begin
                addr_o     = seq_q.pc + ADDR_W'(1);
                seq_d.step = ST_PUSH0;
            end
            ST_PUSH0, ST_PUSH1, ST_PUSH2: begin
                addr_o   = {STACK_PAGE, seq_q.sp};
                rw_o     = is_reset;
                push_idx = (seq_q.step == ST_PUSH0) ? 2'd0 :
                           (seq_q.step == ST_PUSH1) ? 2'd1 : 2'd2;
                seq_d.sp = seq_q.sp - DATA_W'(1);
                seq_d.step = (seq_q.step == ST_PUSH0) ? ST_PUSH1 :
                             (seq_q.step == ST_PUSH1) ? ST_PUSH2 : ST_VLO;
            end
            ST_VLO: begin
                addr_o     = vec_lo_addr;
                seq_d.vlo  = rdata_i;
                seq_d.step = ST_VHI;
            end
            ST_VHI: begin
                addr_o     = vec_lo_addr + ADDR_W'(1);
                seq_d.vhi  = rdata_i;
                seq_d.step = ST_FETCH;
            end
            ST_FETCH: begin
                addr_o     = new_pc;
                done_o     = 1'b1;
                seq_d.step = ST_IDLE;
            end
            default: seq_d.step = ST_IDLE;
        endcase
    end

    assign wdata_o = push_byte;
    assign busy_o  = (seq_q.step != ST_IDLE);
    assign pc_o    = new_pc;
    assign sp_o    = seq_q.sp;
    assign p_o     = seq_q.st | IDIS_MASK;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.step  <= ST_LEAD0;
            seq_q.cause <= CAUSE_RESET;
        end else begin
            seq_q <= seq_d;
        end
    end
endmodule

// File: rtl/entry_seq_chk.sv
module entry_seq_chk #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter logic [ADDR_W-DATA_W-1:0] STACK_PAGE = 1,
    parameter int IDIS_BIT = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   addr,
    input logic                rw,
    input logic                busy,
    input logic                done,
    input logic [DATA_W-1:0]   p_out
);
    localparam logic [ADDR_W-1:0] VEC_FLOOR = '1 - ADDR_W'(5);

    // R3
    write_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rw |-> addr[ADDR_W-1:DATA_W] == STACK_PAGE);

    // R2
    push_descend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rw && !$past(rw)) |-> addr[DATA_W-1:0] == $past(addr[DATA_W-1:0]) - DATA_W'(1));

    // R4
    vec_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && addr >= VEC_FLOOR) |-> rw);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R6
    idis_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> p_out[IDIS_BIT]);

    // R10
    lead_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> rw);
endmodule

bind irq_entry_seq entry_seq_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STACK_PAGE(STACK_PAGE), .IDIS_BIT(IDIS_BIT)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (addr_o),
    .rw    (rw_o),
    .busy  (busy_o),
    .done  (done_o),
    .p_out (p_o)
);

// File: tb/test_irq_entry_seq.sv
module test_irq_entry_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  cause_i = 2'd0;
    logic [15:0] pc_i = '0;
    logic [7:0]  sp_i = '0;
    logic [7:0]  p_i = '0;
    logic [7:0]  rdata_i;
    logic [15:0] addr_o;
    logic [7:0]  wdata_o;
    logic        rw_o, busy_o, done_o;
    logic [15:0] pc_o;
    logic [7:0]  sp_o, p_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    irq_entry_seq i_irq_entry_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cause_i(cause_i),
        .pc_i(pc_i), .sp_i(sp_i), .p_i(p_i), .rdata_i(rdata_i),
        .addr_o(addr_o), .wdata_o(wdata_o), .rw_o(rw_o), .busy_o(busy_o),
        .done_o(done_o), .pc_o(pc_o), .sp_o(sp_o), .p_o(p_o)
    );

    // Memory model: distinct vector bytes at the top of memory.
    always_comb begin
        case (addr_o)
            16'hFFFA: rdata_i = 8'h34;
            16'hFFFB: rdata_i = 8'h12;
            16'hFFFC: rdata_i = 8'h78;
            16'hFFFD: rdata_i = 8'h56;
            16'hFFFE: rdata_i = 8'hBC;
            16'hFFFF: rdata_i = 8'h9A;
            default:  rdata_i = 8'hA5;
        endcase
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    logic [15:0] a_rec [1:8];
    logic        rw_rec [1:8];
    logic [7:0]  wd_rec [1:8];
    logic        dn_rec [1:8];

    // One whole entry; is_rst selects the reset path, glitch pokes start while busy.
    task automatic run_seq(input bit is_rst, input logic [1:0] cause,
                           input logic [15:0] pc, input logic [7:0] sp,
                           input logic [7:0] p, input bit glitch);
        logic [15:0] vec, exp_pc, ret;
        logic [7:0]  pst;
        bit          ok;
        string       tag;
        if (is_rst) begin
            @(negedge clk);
            rst_n = 1'b0;
            pc_i = pc; sp_i = sp; p_i = p;
            @(negedge clk);
            #1;
            chk(busy_o && rw_o && !done_o, "R1", "in-reset state",
                {busy_o, rw_o, done_o}, 3'b110);
            @(negedge clk);
            rst_n = 1'b1;
        end else begin
            @(negedge clk);
            pc_i = pc; sp_i = sp; p_i = p; cause_i = cause; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        for (int i = 1; i <= 8; i++) begin
            if (i > 1) @(negedge clk);
            if (glitch && i == 3) begin start_i = 1'b1; cause_i = 2'd1; end
            if (glitch && i == 4) begin start_i = 1'b0; cause_i = cause; end
            #1;
            a_rec[i] = addr_o; rw_rec[i] = rw_o; wd_rec[i] = wdata_o; dn_rec[i] = done_o;
        end
        // expectations
        if (is_rst)           vec = 16'hFFFC;
        else if (cause == 1)  vec = 16'hFFFA;
        else                  vec = 16'hFFFE;
        exp_pc = (vec == 16'hFFFA) ? 16'h1234 : (vec == 16'hFFFC) ? 16'h5678 : 16'h9ABC;
        ret = (!is_rst && cause == 3) ? pc + 16'd2 : pc;
        pst = p;
        pst[4] = (!is_rst && cause == 3);
        tag = is_rst ? "R1" : "R3";

        chk(rw_rec[1] && rw_rec[2], "R10", "lead-in reads", {rw_rec[1], rw_rec[2]}, 2'b11);
        chk(a_rec[3] == {8'h01, sp}, "R2", "stack addr c3", a_rec[3], {8'h01, sp});
        chk(a_rec[4] == {8'h01, sp - 8'd1}, "R2", "stack addr c4", a_rec[4], {8'h01, sp - 8'd1});
        chk(a_rec[5] == {8'h01, sp - 8'd2}, "R2", "stack addr c5", a_rec[5], {8'h01, sp - 8'd2});
        if (is_rst) begin
            ok = 1;
            for (int i = 1; i <= 8; i++) ok &= rw_rec[i];
            chk(ok, "R1", "reads only", {rw_rec[3], rw_rec[4], rw_rec[5]}, 3'b111);
        end else begin
            chk(!rw_rec[3] && !rw_rec[4] && !rw_rec[5] && rw_rec[6] && rw_rec[7] && rw_rec[8],
                "R3", "strobe pattern",
                {rw_rec[3], rw_rec[4], rw_rec[5], rw_rec[6], rw_rec[7], rw_rec[8]}, 6'b000111);
            chk(wd_rec[3] == ret[15:8], "R7", "pushed PC high", wd_rec[3], ret[15:8]);
            chk(wd_rec[4] == ret[7:0], "R7", "pushed PC low", wd_rec[4], ret[7:0]);
            chk(wd_rec[5] == pst, "R7", "pushed status", wd_rec[5], pst);
        end
        chk(a_rec[6] == vec, "R4", "vector low addr", a_rec[6], vec);
        chk(a_rec[7] == vec + 16'd1, "R4", "vector high addr", a_rec[7], vec + 16'd1);
        chk(a_rec[8] == exp_pc, "R5", "fetch addr", a_rec[8], exp_pc);
        chk(pc_o == exp_pc, "R5", "pc_o", pc_o, exp_pc);
        chk(sp_o == sp - 8'd3, "R8", "sp_o", sp_o, sp - 8'd3);
        chk(p_o == (p | 8'h04), "R6", "p_o", p_o, p | 8'h04);
        ok = dn_rec[8];
        for (int i = 1; i <= 7; i++) ok &= !dn_rec[i];
        chk(ok, "R9", "done only on cycle 8", dn_rec[8], 1'b1);
        @(negedge clk);
        #1;
        chk(!busy_o && !done_o, "R9", "idle after done", {busy_o, done_o}, 2'b00);
        if (is_rst)
            chk(a_rec[8] == 16'h5678, tag, "reset fetch on cycle 8", a_rec[8], 16'h5678);
    endtask

    task automatic t_reset_basic();     run_seq(1, 2'd0, 16'h4000, 8'hFD, 8'h00, 0); endtask
    task automatic t_reset_wrap();      run_seq(1, 2'd0, 16'h0000, 8'h00, 8'h81, 0); endtask
    task automatic t_irq_clear_b();     run_seq(0, 2'd2, 16'h1234, 8'hFF, 8'h30, 0); endtask
    task automatic t_nmi_wrap();        run_seq(0, 2'd1, 16'h8000, 8'h01, 8'hC1, 0); endtask
    task automatic t_brk_plus2();       run_seq(0, 2'd3, 16'h0300, 8'h80, 8'h00, 0); endtask
    task automatic t_brk_carry();       run_seq(0, 2'd3, 16'hFFFF, 8'h42, 8'h04, 0); endtask
    task automatic t_start_ignored();   run_seq(0, 2'd2, 16'h2345, 8'h10, 8'h01, 1); endtask

    initial begin
        t_reset_basic();
        t_irq_clear_b();
        t_nmi_wrap();
        t_brk_plus2();
        t_brk_carry();
        t_start_ignored();
        t_reset_wrap();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule